// File: doc/BRIEF.md
# Sub-Word Addressable Register File

This block holds eight 32-bit general-purpose registers and lets each access pick how much of a register it touches. Any register can be used as a whole 32-bit word or as its low 16-bit half. The first four registers (indices 0 to 3) also expose the two bytes of that low half as separate 8-bit operands. The last four (indices 4 to 7) play pointer and index roles and have no byte view.

There is one write port and two read ports. Each port takes a register index and a 2-bit size code: 0 = full word, 1 = low half (bits 15:0), 2 = low byte (bits 7:0), 3 = high byte of the low half (bits 15:8). A narrow write merges into the addressed field and leaves every other bit as it was. A read returns the addressed field right-aligned and zero-extended to 32 bits. A byte request on a register with no byte view is reported on an illegal-access output and has no effect.

Reads are combinational. Writes take effect at the clock edge, so a read in the same cycle as a write to the same register sees the value from before that write.

Top module: `subword_regfile`

## Requirements
- R1: After the active-low reset `rstN`, every register reads as zero.
- R2: A write with size 0 replaces all 32 bits. A size-0 read returns the full register.
- R3: A write with size 1 replaces bits 15:0 with `wrData[15:0]` and keeps bits 31:16. A size-1 read returns bits 15:0 with bits 31:16 of the output at zero.
- R4: On registers 0 to 3, a write with size 2 replaces bits 7:0 with `wrData[7:0]` and keeps all other bits. A size-2 read returns bits 7:0 with output bits 31:8 at zero.
- R5: On registers 0 to 3, a write with size 3 places `wrData[7:0]` into bits 15:8 and keeps all other bits. A size-3 read returns bits 15:8 on output bits 7:0, with output bits 31:8 at zero.
- R6: A write with size 2 or 3 to registers 4 to 7 drives `wrIllegal` high in that cycle and leaves the register unchanged.
- R7: A read with size 2 or 3 from registers 4 to 7 drives that port's illegal flag high and returns zero.
- R8: A read of the register being written in the same cycle returns the old value. The new value appears from the cycle after the clock edge.
- R9: The two read ports select register and size independently of each other.
- R10: While `wrEn` is low, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write request |
| wrIdx | input | 3 | Write register index |
| wrSize | input | 2 | Write size code |
| wrData | input | 32 | Write data, right-aligned |
| wrIllegal | output | 1 | Write request uses a byte size on a register without byte view |
| rdIdxA | input | 3 | Read port A register index |
| rdSizeA | input | 2 | Read port A size code |
| rdDataA | output | 32 | Read port A data, zero-extended |
| rdIllegalA | output | 1 | Read port A illegal byte request |
| rdIdxB | input | 3 | Read port B register index |
| rdSizeB | input | 2 | Read port B size code |
| rdDataB | output | 32 | Read port B data, zero-extended |
| rdIllegalB | output | 1 | Read port B illegal byte request |

## Verification
The properties are evaluated on every cycle. They check that narrow reads are zero-extended and that illegal reads return zero. They check that a full-word write is visible on the next cycle. They check that a register stays put across an idle cycle or an illegal write. Whether a half or byte write preserves exactly the bits outside its field cannot be expressed as one of these properties, and neither can the placement of the high byte. Those behaviours are shown only by the bench sweeps. The sweeps lay a known background word into each register, apply every size of write, and read the register back at every size on both ports.

// File: rtl/subword_regfile_pkg.sv
package subword_regfile_pkg;
  localparam int DATA_W    = 32;
  localparam int NUM_REGS  = 8;
  localparam int BYTE_REGS = 4;
  localparam int IDX_W     = $clog2(NUM_REGS);
  localparam int LANE_W    = 8;
  localparam int LANES     = DATA_W / LANE_W;
  localparam int SIZE_W    = 2;

  typedef enum logic [SIZE_W-1:0] {
    SZ_WORD = 2'd0,
    SZ_HALF = 2'd1,
    SZ_BLO  = 2'd2,
    SZ_BHI  = 2'd3
  } accSize_e;

  typedef struct packed {
    logic [NUM_REGS-1:0] regSel;
    logic [LANES-1:0]    laneEn;
    logic                hiLane;
  } wrStrobe_t;

  function automatic logic isByteSize(accSize_e s);
    return (s == SZ_BLO) || (s == SZ_BHI);
  endfunction
endpackage

// File: rtl/subword_regfile_ctrl.sv
module subword_regfile_ctrl
  import subword_regfile_pkg::*;
(
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  accSize_e         wrSize,
  input  logic [IDX_W-1:0] rdIdxA,
  input  accSize_e         rdSizeA,
  input  logic [IDX_W-1:0] rdIdxB,
  input  accSize_e         rdSizeB,
  output wrStrobe_t        strobe,
  output logic             wrIllegal,
  output logic             rdIllegalA,
  output logic             rdIllegalB
);
  localparam logic [IDX_W-1:0] BYTE_LIM = IDX_W'(BYTE_REGS);

  function automatic logic noByteView(logic [IDX_W-1:0] idx, accSize_e s);
    return isByteSize(s) && (idx >= BYTE_LIM);
  endfunction

  logic wrBad;

  always_comb begin
    wrBad      = noByteView(wrIdx, wrSize);
    wrIllegal  = wrEn && wrBad;
    rdIllegalA = noByteView(rdIdxA, rdSizeA);
    rdIllegalB = noByteView(rdIdxB, rdSizeB);
    strobe     = '0;
    if (wrEn && !wrBad) begin
      strobe.regSel[wrIdx] = 1'b1;
      unique case (wrSize)
        SZ_WORD: strobe.laneEn = '1;
        SZ_HALF: strobe.laneEn = LANES'(2'b11);
        SZ_BLO:  strobe.laneEn = LANES'(2'b01);
        SZ_BHI: begin
          strobe.laneEn = LANES'(2'b10);
          strobe.hiLane = 1'b1;
        end
        default: strobe.laneEn = '0;
      endcase
    end
  end
endmodule

// File: rtl/subword_regfile_dp.sv
module subword_regfile_dp
  import subword_regfile_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobe_t         strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [IDX_W-1:0]  rdIdxA,
  input  accSize_e          rdSizeA,
  input  logic              rdIllegalA,
  input  logic [IDX_W-1:0]  rdIdxB,
  input  accSize_e          rdSizeB,
  input  logic              rdIllegalB,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB
);
  logic [DATA_W-1:0] regs [NUM_REGS];
  logic [DATA_W-1:0] alignedData;

  assign alignedData = strobe.hiLane ? (wrData << LANE_W) : wrData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < NUM_REGS; r++) regs[r] <= '0;
    end else begin
      for (int r = 0; r < NUM_REGS; r++) begin
        if (strobe.regSel[r]) begin
          for (int l = 0; l < LANES; l++) begin
            if (strobe.laneEn[l]) regs[r][l*LANE_W +: LANE_W] <= alignedData[l*LANE_W +: LANE_W];
          end
        end
      end
    end
  end

  function automatic logic [DATA_W-1:0] extract(logic [DATA_W-1:0] w, accSize_e s, logic bad);
    logic [DATA_W-1:0] res;
    res = '0;
    if (!bad) begin
      unique case (s)
        SZ_WORD: res = w;
        SZ_HALF: res[2*LANE_W-1:0] = w[2*LANE_W-1:0];
        SZ_BLO:  res[LANE_W-1:0]   = w[LANE_W-1:0];
        SZ_BHI:  res[LANE_W-1:0]   = w[2*LANE_W-1:LANE_W];
        default: res = '0;
      endcase
    end
    return res;
  endfunction

  assign rdDataA = extract(regs[rdIdxA], rdSizeA, rdIllegalA);
  assign rdDataB = extract(regs[rdIdxB], rdSizeB, rdIllegalB);
endmodule

// File: rtl/subword_regfile.sv
module subword_regfile
  import subword_regfile_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [SIZE_W-1:0] wrSize,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrIllegal,
  input  logic [IDX_W-1:0]  rdIdxA,
  input  logic [SIZE_W-1:0] rdSizeA,
  output logic [DATA_W-1:0] rdDataA,
  output logic              rdIllegalA,
  input  logic [IDX_W-1:0]  rdIdxB,
  input  logic [SIZE_W-1:0] rdSizeB,
  output logic [DATA_W-1:0] rdDataB,
  output logic              rdIllegalB
);
  wrStrobe_t strobe;

  subword_regfile_ctrl u_ctrl (
    .wrEn       (wrEn),
    .wrIdx      (wrIdx),
    .wrSize     (accSize_e'(wrSize)),
    .rdIdxA     (rdIdxA),
    .rdSizeA    (accSize_e'(rdSizeA)),
    .rdIdxB     (rdIdxB),
    .rdSizeB    (accSize_e'(rdSizeB)),
    .strobe     (strobe),
    .wrIllegal  (wrIllegal),
    .rdIllegalA (rdIllegalA),
    .rdIllegalB (rdIllegalB)
  );

  subword_regfile_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .wrData     (wrData),
    .rdIdxA     (rdIdxA),
    .rdSizeA    (accSize_e'(rdSizeA)),
    .rdIllegalA (rdIllegalA),
    .rdIdxB     (rdIdxB),
    .rdSizeB    (accSize_e'(rdSizeB)),
    .rdIllegalB (rdIllegalB),
    .rdDataA    (rdDataA),
    .rdDataB    (rdDataB)
  );
endmodule

// File: rtl/subword_regfile_chk.sv
module subword_regfile_chk
  import subword_regfile_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [IDX_W-1:0]  wrIdx,
  input logic [SIZE_W-1:0] wrSize,
  input logic [DATA_W-1:0] wrData,
  input logic              wrIllegal,
  input logic [IDX_W-1:0]  rdIdxA,
  input logic [SIZE_W-1:0] rdSizeA,
  input logic [DATA_W-1:0] rdDataA,
  input logic              rdIllegalA,
  input logic [IDX_W-1:0]  rdIdxB,
  input logic [SIZE_W-1:0] rdSizeB,
  input logic [DATA_W-1:0] rdDataB,
  input logic              rdIllegalB
);
  p_word_visible_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(wrEn) && $past(wrSize) == 2'd0 && rdIdxA == $past(wrIdx) && rdSizeA == 2'd0)
      |-> rdDataA == $past(wrData));

  p_half_zext_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rdSizeA == 2'd1) |-> rdDataA[DATA_W-1:16] == '0);

  p_byte_zext_r4: assert property (@(posedge clk) disable iff (!rstN)
    rdSizeB[1] |-> rdDataB[DATA_W-1:8] == '0);

  p_illegal_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(wrIllegal) && $past(rdIdxA) == $past(wrIdx) &&
     rdIdxA == $past(rdIdxA) && rdSizeA == $past(rdSizeA))
      |-> rdDataA == $past(rdDataA));

  p_illegal_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rdIllegalA || rdIllegalB) |-> ((!rdIllegalA || rdDataA == '0) && (!rdIllegalB || rdDataB == '0)));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(wrEn) && rdIdxB == $past(rdIdxB) && rdSizeB == $past(rdSizeB))
      |-> $stable(rdDataB));

  logic unusedSig;
  assign unusedSig = ^{wrData[0], rdIllegalB};
endmodule

bind subword_regfile subword_regfile_chk u_chk (.*);

// File: tb/subword_regfile_tb.sv
`timescale 1ns/1ps
module subword_regfile_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn;
  logic [2:0]  wrIdx;
  logic [1:0]  wrSize;
  logic [31:0] wrData;
  logic        wrIllegal;
  logic [2:0]  rdIdxA, rdIdxB;
  logic [1:0]  rdSizeA, rdSizeB;
  logic [31:0] rdDataA, rdDataB;
  logic        rdIllegalA, rdIllegalB;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;
  logic [31:0] model [8];

  always #2.5 clk = ~clk;

  subword_regfile u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrSize(wrSize),
    .wrData(wrData), .wrIllegal(wrIllegal),
    .rdIdxA(rdIdxA), .rdSizeA(rdSizeA), .rdDataA(rdDataA), .rdIllegalA(rdIllegalA),
    .rdIdxB(rdIdxB), .rdSizeB(rdSizeB), .rdDataB(rdDataB), .rdIllegalB(rdIllegalB)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit badReq(int idx, int sz);
    return (sz >= 2) && (idx >= 4);
  endfunction

  function automatic logic [31:0] expRead(int idx, int sz);
    logic [31:0] w = model[idx];
    if (badReq(idx, sz)) return 32'h0;
    case (sz)
      0: return w;
      1: return {16'h0, w[15:0]};
      2: return {24'h0, w[7:0]};
      default: return {24'h0, w[15:8]};
    endcase
  endfunction

  function automatic string readTag(int idx, int sz);
    if (badReq(idx, sz)) return "R7";
    case (sz)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic void applyModel(int idx, int sz, logic [31:0] d);
    if (badReq(idx, sz)) return;
    case (sz)
      0: model[idx] = d;
      1: model[idx][15:0] = d[15:0];
      2: model[idx][7:0] = d[7:0];
      default: model[idx][15:8] = d[7:0];
    endcase
  endfunction

  task automatic doWrite(input int idx, input int sz, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrIdx = idx[2:0]; wrSize = sz[1:0]; wrData = d;
    #1;
    check(wrIllegal == badReq(idx, sz), "R6 flag", {31'h0, wrIllegal}, {31'h0, badReq(idx, sz)});
    @(posedge clk);
    applyModel(idx, sz, d);
    #1 wrEn = 1'b0;
  endtask

  task automatic readCheck(input int ia, input int sa, input int ib, input int sb);
    @(negedge clk);
    rdIdxA = ia[2:0]; rdSizeA = sa[1:0]; rdIdxB = ib[2:0]; rdSizeB = sb[1:0];
    #1;
    check(rdDataA == expRead(ia, sa), readTag(ia, sa), rdDataA, expRead(ia, sa));
    check(rdIllegalA == badReq(ia, sa), "R7 flag A", {31'h0, rdIllegalA}, {31'h0, badReq(ia, sa)});
    check(rdDataB == expRead(ib, sb), "R9 port B", rdDataB, expRead(ib, sb));
    check(rdIllegalB == badReq(ib, sb), "R9 flag B", {31'h0, rdIllegalB}, {31'h0, badReq(ib, sb)});
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; wrEn = 1'b0; wrIdx = '0; wrSize = '0; wrData = '0;
    rdIdxA = '0; rdSizeA = '0; rdIdxB = '0; rdSizeB = '0;
    for (int i = 0; i < 8; i++) model[i] = 32'h0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: every register reads zero after reset
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); rdIdxA = i[2:0]; rdSizeA = 2'd0; #1;
      check(rdDataA == 32'h0, "R1 reset", rdDataA, 32'h0);
    end

    // R2..R7, R9: background word, narrow write, readback at every size
    for (int idx = 0; idx < 8; idx++) begin
      for (int sz = 0; sz < 4; sz++) begin
        for (int p = 0; p < 3; p++) begin
          logic [31:0] bg, d;
          bg = {4{8'(idx * 16 + p + 1)}} ^ 32'hF00F_0FF0;
          d  = 32'hDEAD_BEEF ^ (32'(p) * 32'h1357_9BDF) ^ 32'(idx);
          doWrite(idx, 0, bg);
          doWrite(idx, sz, d);
          for (int rs = 0; rs < 4; rs++) readCheck(idx, rs, idx ^ 1, 3 - rs);
        end
      end
    end

    // R10: data presented with wrEn low changes nothing
    @(negedge clk);
    wrEn = 1'b0; wrIdx = 3'd2; wrSize = 2'd0; wrData = 32'h1234_5678;
    @(posedge clk);
    readCheck(2, 0, 5, 0);
    check(rdDataA == model[2], "R10 idle", rdDataA, model[2]);

    // R8: same-cycle read returns old value, new value after the edge
    @(negedge clk);
    rdIdxA = 3'd3; rdSizeA = 2'd0;
    wrEn = 1'b1; wrIdx = 3'd3; wrSize = 2'd0; wrData = 32'hCAFE_F00D;
    #1;
    check(rdDataA == model[3], "R8 old value", rdDataA, model[3]);
    @(posedge clk);
    model[3] = 32'hCAFE_F00D;
    #1 wrEn = 1'b0;
    check(rdDataA == 32'hCAFE_F00D, "R8 new value", rdDataA, 32'hCAFE_F00D);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule